// File: doc/BRIEF.md
# Double-Buffered Clock Register Window

This block sits inside a byte-wide, SRAM-style address space. Every address except the eight highest reaches a plain byte RAM. The top eight addresses reach a bank of clock registers instead. Software reads and writes these registers with the same bus cycles it uses for RAM. Seven of the registers hold a visible copy of the time fields. The eighth is a control register.

The time counter itself lives outside the block. It supplies its live field values and a one-second tick. On each tick the visible copy is refreshed from the live fields, with all fields changing in the same clock cycle. When software sets the halt bit in the control register, refreshing stops and the visible copy keeps the time it held when the halt was written. The external counter keeps running throughout. When the bit is cleared, the first tick that follows copies every field at once.

A power-fail flag forces the chip deselected, which blocks every RAM and register access. The flag is also reflected on an active-low output.

Top module: `rtcwin`

## Requirements
- R1: Addresses whose upper ADDR_W-3 bits are all ones select the clock register bank. Every other address selects RAM. A RAM write never changes a clock register, and a register write never changes RAM.
- R2: A write is applied on the clock edge at which weN is first sampled high after being sampled low, provided ceN is low and pwrFail is low at that edge. rdDrive is 1 only while ceN is low, oeN is low, weN is high and pwrFail is low. rdData is 0 whenever rdDrive is 0.
- R3: Within the register bank, the offset is the low three address bits. Offset 0 is control, 1 is seconds, 2 is minutes, 3 is hours, 4 is day of week, 5 is date, 6 is month and 7 is year. Live field byte k, which is liveTime[8k+7:8k], feeds offset k+1.
- R4: With the halt bit clear, a secTick pulse copies all seven live bytes into the visible registers on the same clock edge.
- R5: Control bit 6 is the halt bit, and the control register reads back as written. While the halt bit is 1, secTick pulses leave every visible time register unchanged.
- R6: After the halt bit is cleared, the visible registers keep their held values until the next secTick, and that tick refreshes all seven of them.
- R7: If a control write and a secTick fall on the same edge, the written halt bit decides whether that tick refreshes: it is suppressed when the bit is 1 and performed when it is 0.
- R8: While pwrFail is 1, pfailN is 0, rdDrive is 0, and writes to RAM and to registers are ignored. pfailN is 1 while pwrFail is 0.
- R9: After reset, the control register and all visible time registers read 0 and rdDrive is 0.
- R10: A write to a time register replaces its visible value. The written value then reads back until the next refresh, including while halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address |
| wrData | input | 8 | Write data |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable; a write is applied on its rising edge |
| pwrFail | input | 1 | Supply out of tolerance |
| secTick | input | 1 | One-cycle pulse, once per second, from the time counter |
| liveTime | input | 56 | Live time fields from the counter, seconds in the low byte |
| rdData | output | 8 | Read data, 0 when not driven |
| rdDrive | output | 1 | Read data valid for driving onto the bus |
| pfailN | output | 1 | Active-low power-fail indication |

## Verification
A control-register write and the one-second refresh can land on the same clock edge. Whether that refresh happens is then decided by the halt bit being written, not by the one already stored. The bench provokes this by raising secTick on exactly the cycle in which weN returns high for a control write. It does this once to set the halt bit and once to clear it. In each case it reads all seven time fields back and compares them with a model that applies the new halt value first. Time-register writes that fall on a refresh edge are also drawn at random, and there the refresh is expected to overwrite the written byte.

// File: rtl/rtcwin_pkg.sv
package rtcwin_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 8;
  localparam int OFF_W    = $clog2(NUM_REGS);
  localparam int HALT_BIT = 6;
  localparam int LIVE_W   = BYTE_W * (NUM_REGS - 1);

  // strobes from control to datapath
  typedef struct packed {
    logic ramWr;
    logic ctrlWr;
    logic timeWr;
    logic refresh;
    logic winSel;
    logic drive;
  } winStb_t;
endpackage

// File: rtl/rtcwin_ctrl.sv
module rtcwin_ctrl
  import rtcwin_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              pwrFail,
  input  logic              secTick,
  input  logic              newHaltBit,
  input  logic              haltQ,
  output winStb_t           stb,
  output logic [OFF_W-1:0]  regOff
);
  logic weDly;
  logic chipOn;
  logic wrEdge;
  logic haltNext;

  always_ff @(posedge clk) begin
    if (!rstN) weDly <= 1'b1;
    else       weDly <= weN;
  end

  always_comb begin
    chipOn     = !ceN && !pwrFail;
    wrEdge     = chipOn && weN && !weDly;
    regOff     = addr[OFF_W-1:0];
    stb.winSel = &addr[ADDR_W-1:OFF_W];
    stb.ramWr  = wrEdge && !stb.winSel;
    stb.ctrlWr = wrEdge && stb.winSel && (regOff == '0);
    stb.timeWr = wrEdge && stb.winSel && (regOff != '0);
    // a halt write on a tick edge decides that tick
    haltNext    = stb.ctrlWr ? newHaltBit : haltQ;
    stb.refresh = secTick && !haltNext;
    stb.drive   = chipOn && !oeN && weN;
  end
endmodule

// File: rtl/rtcwin_dp.sv
module rtcwin_dp
  import rtcwin_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [LIVE_W-1:0] liveTime,
  input  winStb_t           stb,
  input  logic [OFF_W-1:0]  regOff,
  output logic              haltQ,
  output logic [BYTE_W-1:0] rdData
);
  localparam int RAM_DEPTH = (1 << ADDR_W) - NUM_REGS;

  logic [BYTE_W-1:0] ramArr [RAM_DEPTH];
  logic [BYTE_W-1:0] regArr [NUM_REGS];

  always_ff @(posedge clk) begin
    if (stb.ramWr) ramArr[addr] <= wrData;
  end

  // slot 0 is the control register
  always_ff @(posedge clk) begin
    if (!rstN)          regArr[0] <= '0;
    else if (stb.ctrlWr) regArr[0] <= wrData;
  end

  for (genvar f = 1; f < NUM_REGS; f++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rstN)
        regArr[f] <= '0;
      else if (stb.refresh)
        regArr[f] <= liveTime[BYTE_W*(f-1) +: BYTE_W];
      else if (stb.timeWr && (regOff == OFF_W'(f)))
        regArr[f] <= wrData;
    end
  end

  assign haltQ = regArr[0][HALT_BIT];

  always_comb begin
    if (!stb.drive)      rdData = '0;
    else if (stb.winSel) rdData = regArr[regOff];
    else                 rdData = ramArr[addr];
  end
endmodule

// File: rtl/rtcwin.sv
module rtcwin
  import rtcwin_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              pwrFail,
  input  logic              secTick,
  input  logic [55:0]       liveTime,
  output logic [7:0]        rdData,
  output logic              rdDrive,
  output logic              pfailN
);
  winStb_t          stb;
  logic [OFF_W-1:0] regOff;
  logic             haltBit;

  rtcwin_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .oeN(oeN), .weN(weN),
    .pwrFail(pwrFail), .secTick(secTick), .newHaltBit(wrData[HALT_BIT]),
    .haltQ(haltBit), .stb(stb), .regOff(regOff)
  );

  rtcwin_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .liveTime(liveTime),
    .stb(stb), .regOff(regOff), .haltQ(haltBit), .rdData(rdData)
  );

  assign rdDrive = stb.drive;
  assign pfailN  = !pwrFail;
endmodule

// File: rtl/rtcwin_chk.sv
module rtcwin_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic              pwrFail,
  input logic              haltBit,
  input logic [7:0]        rdData,
  input logic              rdDrive,
  input logic              pfailN
);
  // R8
  pfail_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |-> !pfailN);

  // R8
  pfail_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |-> !rdDrive);

  // R2
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || oeN || !weN) |-> (!rdDrive && rdData == 8'h00));

  // R5
  halt_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (haltBit && $past(haltBit) && rdDrive && $past(rdDrive) && $past(weN, 2)
     && $stable(addr) && (&addr[ADDR_W-1:3]) && (addr[2:0] != 3'd0))
    |-> $stable(rdData));
endmodule

bind rtcwin rtcwin_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .oeN(oeN), .weN(weN),
  .pwrFail(pwrFail), .haltBit(haltBit), .rdData(rdData), .rdDrive(rdDrive),
  .pfailN(pfailN)
);

// File: tb/rtcwin_bench.sv
module rtcwin_bench;
  localparam int AW  = 8;
  localparam int TOP = (1 << AW) - 1;
  localparam int CTL = TOP - 7;

  logic clk = 0, rstN = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic ceN = 1, oeN = 1, weN = 1, pwrFail = 0, secTick = 0;
  logic [55:0] liveTime = '0;
  logic [7:0] rdData;
  logic rdDrive, pfailN;

  int nChk = 0, nBad = 0;
  logic [7:0] mRam [1 << AW];
  logic [7:0] mReg [8];

  always #4 clk = ~clk;

  rtcwin #(.ADDR_W(AW)) u_rtcwin (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .ceN(ceN),
    .oeN(oeN), .weN(weN), .pwrFail(pwrFail), .secTick(secTick),
    .liveTime(liveTime), .rdData(rdData), .rdDrive(rdDrive), .pfailN(pfailN)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(logic [AW-1:0] a);
    if (&a[AW-1:3]) return mReg[a[2:0]];
    return mRam[a];
  endfunction

  function automatic logic modelHalt();
    return mReg[0][6];
  endfunction

  task automatic modelRefresh();
    for (int f = 1; f < 8; f++) mReg[f] = liveTime[8*(f-1) +: 8];
  endtask

  task automatic modelWrite(logic [AW-1:0] a, logic [7:0] d);
    if (&a[AW-1:3]) mReg[a[2:0]] = d;
    else mRam[a] = d;
  endtask

  // tickOnEdge raises secTick in the cycle in which the write lands
  task automatic busWrite(logic [AW-1:0] a, logic [7:0] d, bit tickOnEdge);
    @(negedge clk); addr = a; wrData = d; ceN = 0; oeN = 1; weN = 0;
    @(negedge clk); weN = 1; secTick = tickOnEdge;
    @(negedge clk); ceN = 1; secTick = 0;
    if (!pwrFail) begin
      if (&a[AW-1:3] && a[2:0] == 3'd0) begin
        mReg[0] = d;
        if (tickOnEdge && !modelHalt()) modelRefresh();
      end else begin
        if (tickOnEdge && !modelHalt()) modelRefresh();
        else modelWrite(a, d);
        if (!(&a[AW-1:3])) modelWrite(a, d);
      end
    end else if (tickOnEdge && !modelHalt()) modelRefresh();
  endtask

  task automatic busRead(logic [AW-1:0] a, string req);
    @(negedge clk); addr = a; ceN = 0; oeN = 0; weN = 1;
    #1;
    check(req, {7'd0, rdDrive}, {7'd0, !pwrFail});
    check(req, rdData, pwrFail ? 8'h00 : expRead(a));
    @(negedge clk); ceN = 1; oeN = 1;
  endtask

  task automatic tick();
    @(negedge clk); secTick = 1;
    @(negedge clk); secTick = 0;
    if (!modelHalt()) modelRefresh();
  endtask

  task automatic readFields(string req);
    for (int f = 0; f < 8; f++) busRead(AW'(CTL + f), req);
  endtask

  initial begin
    #1_500_000;
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd9173));
    for (int i = 0; i < 8; i++) mReg[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R9 reset state
    #1;
    check("R9 drive idle", {7'd0, rdDrive}, 8'h00);
    check("R8 pfailN idle", {7'd0, pfailN}, 8'h01);
    readFields("R9 reset regs");

    // R1 fill RAM, then check registers untouched
    for (int a = 0; a < CTL; a++) busWrite(AW'(a), 8'(a * 7 + 3), 1'b0);
    busWrite(AW'(CTL - 1), 8'hA5, 1'b0);
    readFields("R1 regs untouched by RAM write");
    busRead(AW'(CTL - 1), "R1 RAM below window");
    busRead(AW'(0), "R1 RAM bottom");

    // R3 R4 refresh with a distinct byte per field
    liveTime = 56'h07_06_05_04_03_02_01;
    tick();
    readFields("R3 R4 field map");
    busRead(AW'(CTL - 1), "R1 RAM untouched by register write");

    // R5 halt holds fields; R10 write while halted
    busWrite(AW'(CTL), 8'h40, 1'b0);
    busRead(AW'(CTL), "R5 control readback");
    liveTime = 56'h99_12_31_07_23_59_58;
    repeat (3) tick();
    readFields("R5 frozen under halt");
    busWrite(AW'(CTL + 2), 8'h42, 1'b0);
    busRead(AW'(CTL + 2), "R10 write while halted");
    tick();
    busRead(AW'(CTL + 2), "R10 held while halted");

    // R6 release
    busWrite(AW'(CTL), 8'h00, 1'b0);
    repeat (62600) @(negedge clk);
    readFields("R6 held until tick");
    tick();
    readFields("R6 all fields refreshed");

    // R10 time write then refresh
    busWrite(AW'(CTL + 1), 8'h33, 1'b0);
    busRead(AW'(CTL + 1), "R10 written value");
    liveTime = 56'h24_02_29_04_11_22_33;
    tick();
    busRead(AW'(CTL + 1), "R10 overwritten by refresh");

    // R7 collisions
    liveTime = 56'h25_03_01_05_00_00_01;
    busWrite(AW'(CTL), 8'h40, 1'b1);
    readFields("R7 halt wins over tick");
    busWrite(AW'(CTL), 8'h00, 1'b1);
    readFields("R7 release tick refreshes");

    // R8 power fail blocks everything
    @(negedge clk); pwrFail = 1;
    #1; check("R8 pfailN low", {7'd0, pfailN}, 8'h00);
    busWrite(AW'(5), 8'hEE, 1'b0);
    busWrite(AW'(CTL + 3), 8'hEE, 1'b0);
    busWrite(AW'(CTL), 8'h40, 1'b0);
    busRead(AW'(5), "R8 drive blocked");
    @(negedge clk); pwrFail = 0;
    #1; check("R8 pfailN released", {7'd0, pfailN}, 8'h01);
    busRead(AW'(5), "R8 RAM write ignored");
    readFields("R8 register writes ignored");

    // R2 drive gating with oeN high
    @(negedge clk); addr = AW'(CTL + 1); ceN = 0; oeN = 1;
    #1; check("R2 no drive with oeN high", {7'd0, rdDrive}, 8'h00);
    check("R2 zero data when idle", rdData, 8'h00);
    @(negedge clk); ceN = 1;

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      logic [AW-1:0] a = ($urandom_range(0, 1) == 1)
                         ? AW'(CTL + $urandom_range(0, 7)) : AW'($urandom);
      liveTime = {$urandom, $urandom}[55:0];
      if (op < 4)       busWrite(a, (a == AW'(CTL)) ? 8'($urandom_range(0,1) << 6) : 8'($urandom), op == 3);
      else if (op < 8)  busRead(a, "R2 R4 random access");
      else              tick();
    end
    readFields("R4 R5 final state");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule